// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block finds basic frame alignment in a received E1 bit stream. The frames are 256 bits long, and the alignment word appears only in every second frame. An upstream line interface supplies one data bit at a time, with a strobe that marks the cycles that carry a real bit. The block slides a 7-bit window along the stream until the window equals the alignment pattern. It then anchors its bit counter to that spot. Before it declares lock it requires two further events: a one in the second bit of the following non-alignment frame, and a correct alignment word in the frame after that.

Downstream logic reads three outputs. The first is the position of the most recent bit within its frame. The second is a flag that marks whether that frame is an alignment frame or a non-alignment frame. The third is an active-low status that is low only while lock is held. Once lock is held, the block drops it after a fixed number of consecutive errored alignment words and starts the hunt again. A reframe request returns the block to the hunt on any cycle.

Top module: `e1_frame_align`

## Requirements
- R1: After reset, `sync_n` is 1, `bit_pos` is 0 and `fas_frame` is 0.
- R2: In the hunt, the alignment pattern is 0011011, matched with its first received bit as the leftmost digit. When the bit that completes this pattern is accepted, `bit_pos` becomes 7 and `fas_frame` becomes 1 on the next cycle, and `sync_n` stays 1. This happens wherever the pattern falls in the stream.
- R3: Each accepted bit (`bit_vld` = 1) advances `bit_pos` by one. The step from 255 wraps to 0 and inverts `fas_frame`. Cycles with `bit_vld` = 0 leave both outputs unchanged.
- R4: After a detection, the bit at position 1 of the next frame (with `fas_frame` = 0) is checked. If that bit is 0, the block returns to the hunt, and a correct alignment word one frame later does not give lock.
- R5: If that bit is 1 and the bits at positions 1 to 7 of the following frame (with `fas_frame` = 1) equal 0011011, then `sync_n` goes to 0 on the cycle after position 7 is accepted.
- R6: If the confirming alignment word is wrong, `sync_n` stays 1 and the hunt restarts.
- R7: While locked, three consecutive errored alignment words set `sync_n` to 1 on the cycle after the third word's position 7. A correct word clears the error run.
- R8: A cycle with `reframe` = 1 sets `sync_n` to 1 on the next cycle and restarts the hunt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Received serial data bit |
| bit_vld | input | 1 | High on cycles where `bit_in` carries a bit |
| reframe | input | 1 | Request to discard alignment and hunt again |
| bit_pos | output | 8 | Position of the last accepted bit in its frame |
| fas_frame | output | 1 | 1 when the current frame carries the alignment word |
| sync_n | output | 1 | 0 while basic frame alignment is held |

## Verification
The hardest situation to reach from the ports is the loss rule. It needs the block locked first, then a series of errored alignment words that includes a correct word partway through, to show that the error run restarts. This is followed by a run of exactly three errored words. The bench builds whole frames from a bit function and a few flags: alignment frame or not, word correct or corrupted, and the value of the non-alignment bit. It drives these frames at half rate, so every frame also exercises the strobe gaps. A reframe in the middle of a frame, followed by a slip of 37 bits, moves the hunt to a new offset. This shows that detection depends only on the pattern and not on the old count.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_NFAS    = 2'd1,
    ST_CONFIRM = 2'd2,
    ST_LOCKED  = 2'd3
  } align_state_t;
endpackage

// File: rtl/e1fa_window.sv
module e1fa_window #(
  parameter int          PAT_LEN = 7,
  parameter logic [6:0]  PATTERN = 7'b0011011
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic match
);
  localparam int HIST = PAT_LEN - 1;

  logic [HIST-1:0]    hist_q;
  logic [PAT_LEN-1:0] cand;
  logic [PAT_LEN-1:0] bit_eq;

  assign cand = {hist_q, bit_in};

  for (genvar i = 0; i < PAT_LEN; i++) begin : g_cmp
    assign bit_eq[i] = (cand[i] == PATTERN[i]);
  end

  assign match = &bit_eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (bit_vld) begin
      hist_q <= {hist_q[HIST-2:0], bit_in};
    end
  end
endmodule

// File: rtl/e1fa_position.sv
module e1fa_position #(
  parameter int FRAME_BITS = 256,
  parameter int LOAD_POS   = 7,
  localparam int POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             load,
  output logic [POS_W-1:0] pos_q,
  output logic             frm_q,
  output logic [POS_W-1:0] nxt_pos,
  output logic             nxt_frm
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] LPOS = POS_W'(LOAD_POS);

  always_comb begin
    if (pos_q == LAST) begin
      nxt_pos = '0;
      nxt_frm = ~frm_q;
    end else begin
      nxt_pos = pos_q + 1'b1;
      nxt_frm = frm_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      frm_q <= 1'b0;
    end else if (bit_vld) begin
      if (load) begin
        pos_q <= LPOS;
        frm_q <= 1'b1;
      end else begin
        pos_q <= nxt_pos;
        frm_q <= nxt_frm;
      end
    end
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(pos_q) && $stable(frm_q));

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !load && pos_q == LAST) |=> (pos_q == '0) && (frm_q != $past(frm_q)));
endmodule

// File: rtl/e1fa_seq.sv
module e1fa_seq
  import e1fa_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int FAS_END    = 7,
  parameter int NFAS_POS   = 1,
  parameter int LOSS_LIMIT = 3,
  localparam int POS_W     = $clog2(FRAME_BITS),
  localparam int ERR_W     = $clog2(LOSS_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_vld,
  input  logic             reframe,
  input  logic             match,
  input  logic [POS_W-1:0] nxt_pos,
  input  logic             nxt_frm,
  output logic             load,
  output logic             sync_n
);
  localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(LOSS_LIMIT - 1);

  align_state_t     state_q, state_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             at_fas, at_nfas;

  assign at_fas  = (nxt_pos == POS_W'(FAS_END)) && nxt_frm;
  assign at_nfas = (nxt_pos == POS_W'(NFAS_POS)) && !nxt_frm;

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    load    = 1'b0;
    if (reframe) begin
      state_d = ST_HUNT;
      err_d   = '0;
    end else if (bit_vld) begin
      unique case (state_q)
        ST_HUNT: begin
          if (match) begin
            load    = 1'b1;
            state_d = ST_NFAS;
          end
        end
        ST_NFAS: begin
          if (at_nfas) state_d = bit_in ? ST_CONFIRM : ST_HUNT;
        end
        ST_CONFIRM: begin
          if (at_fas) begin
            state_d = match ? ST_LOCKED : ST_HUNT;
            err_d   = '0;
          end
        end
        ST_LOCKED: begin
          if (at_fas) begin
            if (match) begin
              err_d = '0;
            end else if (err_q == ERR_LAST) begin
              err_d   = '0;
              state_d = ST_HUNT;
            end else begin
              err_d = err_q + 1'b1;
            end
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      err_q   <= '0;
      sync_n  <= 1'b1;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      sync_n  <= (state_d != ST_LOCKED);
    end
  end

  // R8
  reframe_chk: assert property (@(posedge clk) disable iff (rst)
    reframe |=> sync_n && (state_q == ST_HUNT));

  // R5
  lock_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_n) |-> $past(state_q) == ST_CONFIRM);

  // R4
  nfas_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NFAS && bit_vld && !reframe && at_nfas && !bit_in) |=> sync_n && (state_q == ST_HUNT));

  // R7
  loss_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCKED && bit_vld && !reframe && at_fas && !match && err_q == ERR_LAST) |=> sync_n);

  // R2
  hunt_status_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HUNT) |-> sync_n);
endmodule

// File: rtl/e1_frame_align.sv
module e1_frame_align #(
  parameter int         FRAME_BITS = 256,
  parameter int         PAT_LEN    = 7,
  parameter logic [6:0] PATTERN    = 7'b0011011,
  parameter int         NFAS_POS   = 1,
  parameter int         LOSS_LIMIT = 3,
  localparam int        POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_vld,
  input  logic             reframe,
  output logic [POS_W-1:0] bit_pos,
  output logic             fas_frame,
  output logic             sync_n
);
  localparam int FAS_END = PAT_LEN;

  logic             match;
  logic             load;
  logic [POS_W-1:0] nxt_pos;
  logic             nxt_frm;

  e1fa_window #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_window (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .match(match)
  );

  e1fa_position #(.FRAME_BITS(FRAME_BITS), .LOAD_POS(FAS_END)) u_position (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .load(load),
    .pos_q(bit_pos), .frm_q(fas_frame), .nxt_pos(nxt_pos), .nxt_frm(nxt_frm)
  );

  e1fa_seq #(
    .FRAME_BITS(FRAME_BITS), .FAS_END(FAS_END),
    .NFAS_POS(NFAS_POS), .LOSS_LIMIT(LOSS_LIMIT)
  ) u_seq (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .reframe(reframe),
    .match(match), .nxt_pos(nxt_pos), .nxt_frm(nxt_frm),
    .load(load), .sync_n(sync_n)
  );

  // R2
  detect_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !reframe) |=> (bit_pos == POS_W'(FAS_END)) && fas_frame && sync_n);
endmodule

// File: tb/e1_frame_align_bench.sv
module e1_frame_align_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       bit_in;
  logic       bit_vld;
  logic       reframe;
  logic [7:0] bit_pos;
  logic       fas_frame;
  logic       sync_n;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  localparam logic [6:0] PAT = 7'b0011011;

  always #5 clk = ~clk;

  e1_frame_align u_e1_frame_align (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .reframe(reframe),
    .bit_pos(bit_pos), .fas_frame(fas_frame), .sync_n(sync_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic fbit(input logic fas, input logic good, input logic b2, input int p);
    if (fas) begin
      if (p >= 1 && p <= 7) return good ? PAT[7-p] : 1'b1;
      return 1'b1;
    end
    if (p == 1) return b2;
    return 1'b1;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_in  = b;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic send_range(input logic fas, input logic good, input logic b2,
                            input int lo, input int hi);
    for (int p = lo; p <= hi; p++) send_bit(fbit(fas, good, b2, p));
  endtask

  task automatic fas_head(input logic good);
    send_range(1'b1, good, 1'b1, 0, 7);
  endtask

  task automatic fas_tail();
    send_range(1'b1, 1'b1, 1'b1, 8, 255);
  endtask

  task automatic nfas(input logic b2);
    send_range(1'b0, 1'b1, b2, 0, 255);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bit_in = 1'b0; bit_vld = 1'b0; reframe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 sync_n", sync_n, 1);
    chk("R1 bit_pos", bit_pos, 0);
    chk("R1 fas_frame", fas_frame, 0);

    // R3 counting, gaps and wrap during the hunt
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    chk("R3 count", bit_pos, 5);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      bit_in = i[0];
    end
    chk("R3 gap pos", bit_pos, 5);
    chk("R3 gap frm", fas_frame, 0);
    for (int i = 0; i < 300; i++) send_bit(1'b1);
    chk("R3 wrap pos", bit_pos, 49);
    chk("R3 wrap frm", fas_frame, 1);

    // R2 detection, R5 lock
    fas_head(1'b1);
    chk("R2 pos", bit_pos, 7);
    chk("R2 frm", fas_frame, 1);
    chk("R2 sync_n", sync_n, 1);
    fas_tail();
    send_range(1'b0, 1'b1, 1'b1, 0, 1);
    chk("R3 nfas pos", bit_pos, 1);
    chk("R3 nfas frm", fas_frame, 0);
    send_range(1'b0, 1'b1, 1'b1, 2, 255);
    fas_head(1'b1);
    chk("R5 locked", sync_n, 0);
    fas_tail();
    chk("R3 end pos", bit_pos, 255);

    // R7 error run, cleared by a good word, then three in a row
    nfas(1'b1); fas_head(1'b0); chk("R7 err1", sync_n, 0); fas_tail();
    nfas(1'b1); fas_head(1'b0); chk("R7 err2", sync_n, 0); fas_tail();
    nfas(1'b1); fas_head(1'b1); chk("R7 good", sync_n, 0); fas_tail();
    nfas(1'b1); fas_head(1'b0); fas_tail();
    nfas(1'b1); fas_head(1'b0); chk("R7 run of two", sync_n, 0); fas_tail();
    nfas(1'b1); fas_head(1'b0); chk("R7 lost", sync_n, 1); fas_tail();

    // R4 zero in the non-alignment bit
    nfas(1'b1);
    fas_head(1'b1); chk("R2 redetect", bit_pos, 7); fas_tail();
    nfas(1'b0);
    fas_head(1'b1); chk("R4 no lock", sync_n, 1); fas_tail();
    nfas(1'b1);
    fas_head(1'b1); chk("R5 relock", sync_n, 0); fas_tail();

    // R8 reframe mid frame, slip to a new offset
    send_range(1'b0, 1'b1, 1'b1, 0, 99);
    @(negedge clk); reframe = 1'b1;
    @(negedge clk); reframe = 1'b0;
    chk("R8 sync_n", sync_n, 1);
    for (int i = 0; i < 37; i++) send_bit(1'b1);
    send_range(1'b0, 1'b1, 1'b1, 100, 255);
    fas_head(1'b1);
    chk("R2 new offset pos", bit_pos, 7);
    chk("R2 new offset frm", fas_frame, 1);
    chk("R8 no lock yet", sync_n, 1);
    fas_tail();

    // R6 wrong confirming word
    nfas(1'b1);
    fas_head(1'b0); chk("R6 no lock", sync_n, 1); fas_tail();
    nfas(1'b1);
    fas_head(1'b1); chk("R6 fresh detect", sync_n, 1); fas_tail();
    nfas(1'b1);
    fas_head(1'b1); chk("R5 lock again", sync_n, 0); fas_tail();
    chk("R3 last pos", bit_pos, 255);
    chk("R3 last frm", fas_frame, 1);
    send_bit(1'b1);
    chk("R3 wrap to 0", bit_pos, 0);
    chk("R3 wrap frm", fas_frame, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule